// File: doc/BRIEF.md
# Two-Packet Beat Splitter with Ready-Latency Bridge

This block sits between an application transmit source and a packet sink. The source drives a 256-bit beat that may hold the tail of one packet and the head of the next. Two-bit start and end markers show which 128-bit lane holds each boundary. The sink takes 256-bit beats that carry at most one packet, marked by single-bit start and end flags. The block treats every input beat as two 128-bit lanes. It repacks the lanes of each packet in pairs, starting at bit 0 of the output beat. Lanes that lie outside any packet are dropped.

The two sides use different flow-control timing. The source may present a beat only two cycles after the block showed ready. The block may present a beat only three cycles after it saw the sink's ready. A beat FIFO absorbs the difference, and upstream ready falls early enough that beats already promised always fit. On the source side a packet error is flagged on a middle beat. The block latches that flag and moves it onto the packet's output end beat. Unused qwords in an output end beat are forced to zero.

The lane packer is a three-state machine. PK_SEEK waits for a start lane. A start lane that is also an end lane produces a one-lane beat and stays in PK_SEEK (seek_single). A start lane without an end moves to PK_HI (seek_open). PK_HI fills the upper half and emits a beat: an end lane returns to PK_SEEK (hi_close) and any other lane moves to PK_LO (hi_cont). PK_LO fills the lower half: an end lane emits a one-lane beat and returns to PK_SEEK (lo_close), and any other lane moves to PK_HI (lo_fill). The packer takes one lane per cycle. A step that would emit waits until the delayed sink ready allows it.

Top module: `pkt_split_adapter`

## Requirements
- R1: After reset, in_rdy is 1 and out_vld, out_sop, out_eop and out_err are 0.
- R2: in_rdy is 0 whenever the buffer holds more than DEPTH-3 beats. A source that raises in_vld only two cycles after seeing in_rdy high never loses a beat, even while the sink is held off for a long time.
- R3: out_vld is 1 only in a cycle where out_rdy was 1 exactly three cycles earlier.
- R4: in_sop/in_eop value 01 marks the lower lane (bits 127:0) and 10 marks the upper lane (bits 255:128). out_sop and out_eop are 1 only on the first and last output beat of a packet, and they are 0 when out_vld is 0.
- R5: When an input beat holds the end of one packet in the lower lane and the start of the next in the upper lane, the first packet's end goes out on its own beat. The second packet starts at bit 0 of a later beat.
- R6: A packet that starts in the upper lane has all its lanes moved down by 128 bits. Each output beat holds two consecutive lanes of that packet.
- R7: Each output beat carries lane 2k of a packet in bits 127:0 and lane 2k+1 in bits 255:128. When the packet has an odd number of lanes, the upper half of its last beat is zero.
- R8: Lanes that lie outside any packet (between an end and the next start) produce no output.
- R9: in_err bit 0 on any beat inside a packet makes out_err 1 on that packet's end beat. The flag then clears, so the following packet ends with out_err 0. in_err bit 1 has no effect.
- R10: in_empty bit 0 set on the beat with the end marker means the top qword of the end lane is unused. That qword is 0 at the output. in_empty bit 1 is ignored.
- R11: out_err is 1 only on a beat whose out_eop is 1.
- R12: Packets and their lanes leave in the order they arrived, with no extra output beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_rdy | output | 1 | Block can take a beat two cycles later |
| in_vld | input | 1 | Source beat valid |
| in_dat | input | 256 | Source beat data, two 128-bit lanes |
| in_sop | input | 2 | Start marker per lane (01 lower, 10 upper) |
| in_eop | input | 2 | End marker per lane (01 lower, 10 upper) |
| in_empty | input | 2 | Bit 0: top qword of the end lane unused |
| in_err | input | 2 | Bit 0: error in the current packet; bit 1 ignored |
| out_rdy | input | 1 | Sink ready; valid may follow three cycles later |
| out_vld | output | 1 | Output beat valid |
| out_dat | output | 256 | Output beat data, one packet |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_err | output | 1 | Nullify the packet, given with its end beat |

## Verification
The case that stresses the packer most is an input beat that closes one packet and opens the next. The closing packet's replayed error and zeroed qword must appear on one output beat. The opening lane must wait and land at bit 0 of the next beat, not leak into the closing beat. The bench provokes this with runs of three-lane packets laid end to end, some with an error or an unused end qword, while the sink's ready is held high. The same pattern is repeated with ready toggled at random, so these boundaries also meet the three-cycle output gate. A behavioural model lays the packets out as lanes and predicts each output beat. The bench compares the predicted beat with every output beat in the cycle it appears.

// File: rtl/pkt_split_pkg.sv
`timescale 1ns/1ps
package pkt_split_pkg;

    localparam int DATA_W = 256;
    localparam int LANE_W = DATA_W / 2;
    localparam int QW_W   = 64;
    localparam int LANES  = DATA_W / LANE_W;

    // one buffered source beat
    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic [LANES-1:0]  sop;
        logic [LANES-1:0]  eop;
        logic              tail_gap;   // top qword of end lane unused
        logic              err;        // packet error seen on this beat
    } beat_t;

endpackage

// File: rtl/beat_fifo.sv
`timescale 1ns/1ps
module beat_fifo
    import pkt_split_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  beat_t                        din,
    input  logic                         pop,
    output beat_t                        head,
    output logic                         head_vld,
    output logic [$clog2(DEPTH+1)-1:0]   cnt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    beat_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head     = mem[rp];
    assign head_vld = (cnt != '0);
endmodule

// File: rtl/rdy_delay.sv
`timescale 1ns/1ps
module rdy_delay #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= d;
            end
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lane_packer.sv
`timescale 1ns/1ps
module lane_packer
    import pkt_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  beat_t             head,
    input  logic              head_vld,
    input  logic              emit_ok,
    output logic              pop,
    output logic [DATA_W-1:0] o_dat,
    output logic              o_vld,
    output logic              o_sop,
    output logic              o_eop,
    output logic              o_err
);
    typedef enum logic [1:0] {PK_SEEK, PK_LO, PK_HI} pk_st_t;

    pk_st_t            st, st_nx;
    logic              ptr;
    logic [LANE_W-1:0] slot0;
    logic              sop_pend, err_lat;

    logic [LANE_W-1:0] lane, lane_z;
    logic              s, e, in_pkt, want, step, err_acc, sop_nx;
    logic [DATA_W-1:0] beat_nx;

    always_comb begin
        lane   = ptr ? head.dat[DATA_W-1:LANE_W] : head.dat[LANE_W-1:0];
        s      = head.sop[ptr];
        e      = head.eop[ptr];
        lane_z = lane;
        if (e && head.tail_gap) lane_z[LANE_W-1 -: QW_W] = '0;
        in_pkt  = (st != PK_SEEK) || s;
        err_acc = err_lat | (head.err & in_pkt);
        want    = 1'b0;
        sop_nx  = 1'b0;
        st_nx   = st;
        beat_nx = {{LANE_W{1'b0}}, lane_z};
        unique case (st)
            PK_SEEK: begin
                if (s) begin
                    if (e) begin               // seek_single
                        want   = 1'b1;
                        sop_nx = 1'b1;
                    end else begin             // seek_open
                        st_nx  = PK_HI;
                    end
                end
            end
            PK_LO: begin
                if (e) begin                   // lo_close
                    want  = 1'b1;
                    st_nx = PK_SEEK;
                end else begin                 // lo_fill
                    st_nx = PK_HI;
                end
            end
            PK_HI: begin                       // hi_close / hi_cont
                want    = 1'b1;
                beat_nx = {lane_z, slot0};
                sop_nx  = sop_pend;
                st_nx   = e ? PK_SEEK : PK_LO;
            end
            default: ;
        endcase
        step = head_vld && (!want || emit_ok);
        pop  = step && ptr;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)    st <= PK_SEEK;
        else if (step) st <= st_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld    <= 1'b0;
            o_sop    <= 1'b0;
            o_eop    <= 1'b0;
            o_err    <= 1'b0;
            o_dat    <= '0;
            ptr      <= 1'b0;
            slot0    <= '0;
            sop_pend <= 1'b0;
            err_lat  <= 1'b0;
        end else begin
            o_vld <= step && want;
            o_sop <= step && want && sop_nx;
            o_eop <= step && want && e;
            o_err <= step && want && e && err_acc;
            if (step && want) o_dat <= beat_nx;
            if (step) begin
                ptr <= ~ptr;
                if (st_nx == PK_HI && st != PK_HI) begin
                    slot0    <= lane_z;
                    sop_pend <= (st == PK_SEEK);
                end
                if (in_pkt) err_lat <= (want && e) ? 1'b0 : err_acc;
            end
        end
    end
endmodule

// File: rtl/pkt_split_adapter.sv
`timescale 1ns/1ps
module pkt_split_adapter
    import pkt_split_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int IN_LAT  = 2,
    parameter int OUT_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              in_rdy,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    input  logic [1:0]        in_sop,
    input  logic [1:0]        in_eop,
    input  logic [1:0]        in_empty,
    input  logic [1:0]        in_err,
    input  logic              out_rdy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_dat,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err
);
    localparam int CW        = $clog2(DEPTH + 1);
    localparam int RDY_LIMIT = DEPTH - 1 - IN_LAT;
    localparam int GATE_STG  = (OUT_LAT > 1) ? OUT_LAT - 1 : 1;

    logic          push, pop, head_vld, emit_ok;
    beat_t         in_beat, head;
    logic [CW-1:0] fifo_cnt;
    logic          unused_bits;

    assign push        = in_vld;
    assign in_beat     = '{dat: in_dat, sop: in_sop, eop: in_eop,
                           tail_gap: in_empty[0], err: in_err[0]};
    assign unused_bits = ^{in_err[1], in_empty[1]};
    assign in_rdy      = (fifo_cnt <= CW'(RDY_LIMIT));

    beat_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(in_beat), .pop(pop),
        .head(head), .head_vld(head_vld), .cnt(fifo_cnt)
    );

    rdy_delay #(.STAGES(GATE_STG)) u_gate (
        .clk(clk), .rst_n(rst_n), .d(out_rdy), .q(emit_ok)
    );

    lane_packer u_pack (
        .clk(clk), .rst_n(rst_n), .head(head), .head_vld(head_vld),
        .emit_ok(emit_ok), .pop(pop), .o_dat(out_dat), .o_vld(out_vld),
        .o_sop(out_sop), .o_eop(out_eop), .o_err(out_err)
    );
endmodule

// File: rtl/pkt_split_chk.sv
`timescale 1ns/1ps
module pkt_split_chk #(
    parameter int DEPTH   = 8,
    parameter int OUT_LAT = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       out_rdy,
    input logic                       out_vld,
    input logic                       out_sop,
    input logic                       out_eop,
    input logic                       out_err,
    input logic                       push,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    logic [OUT_LAT-1:0] rdy_hist;
    logic               open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_hist <= '0;
            open     <= 1'b0;
        end else begin
            rdy_hist <= {rdy_hist[OUT_LAT-2:0], out_rdy};
            if (out_vld) open <= !out_eop;
        end
    end

    // R3: valid only where the sink's ready was seen OUT_LAT cycles before
    a_r3_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> rdy_hist[OUT_LAT-1]);

    // R2: a promised beat always finds a free slot
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fifo_cnt < ($clog2(DEPTH+1))'(DEPTH)));

    // R11: error flag rides only on an end beat
    a_r11_err_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_err) |-> out_eop);

    // R4: markers quiet without valid
    a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !(out_sop || out_eop || out_err));

    // R7: a start opens a packet, other beats continue an open one
    a_r7_framing: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_sop == !open));
endmodule

bind pkt_split_adapter pkt_split_chk #(.DEPTH(DEPTH), .OUT_LAT(OUT_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_rdy(out_rdy), .out_vld(out_vld),
    .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
    .push(push), .fifo_cnt(fifo_cnt)
);

// File: tb/pkt_split_adapter_test.sv
`timescale 1ns/1ps
module pkt_split_adapter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_rdy, in_vld = 1'b0;
    logic [255:0] in_dat = '0;
    logic [1:0]   in_sop = '0, in_eop = '0, in_empty = '0, in_err = '0;
    logic         out_rdy = 1'b0;
    logic         out_vld, out_sop, out_eop, out_err;
    logic [255:0] out_dat;

    always #4 clk = ~clk;   // 125 MHz

    pkt_split_adapter uut (
        .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .in_vld(in_vld),
        .in_dat(in_dat), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .in_err(in_err), .out_rdy(out_rdy), .out_vld(out_vld), .out_dat(out_dat),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err)
    );

    // lane-level model of the source stream
    logic [127:0] ln_dat[$];
    bit           ln_sop[$], ln_eop[$], ln_err[$], ln_junk[$], ln_uns[$];
    // predicted output beats
    logic [255:0] ex_dat[$];
    bit           ex_sop[$], ex_eop[$], ex_err[$];
    string        ex_tag[$];

    int checks = 0, errors = 0, cyc = 0, omode = 2;
    bit o0, o1, o2, h0, h1;

    task automatic fail(input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic idle_lane();
        ln_dat.push_back({4{32'hDEAD_BEEF}});
        ln_sop.push_back(0); ln_eop.push_back(0); ln_err.push_back(0);
        ln_junk.push_back(0); ln_uns.push_back(0);
    endtask

    // n lanes (1..8); err needs n>=5 so its beat lies strictly inside the packet
    task automatic add_pkt(input int id, input int n, input bit err,
                           input bit uns, input bit junk, input int gap);
        string        tag;
        int           pos;
        logic [127:0] v, el[8];
        for (int g = 0; g < gap; g++) idle_lane();
        pos = ln_dat.size() % 2;
        if (pos == 1 && (n == 1 || ln_sop[ln_sop.size()-1])) begin
            idle_lane();
            pos = 0;
        end
        if (pos == 1) tag = ln_eop[ln_eop.size()-1] ? "R5" : "R6";
        else          tag = (gap > 0) ? "R8" : "R7";
        for (int i = 0; i < n; i++) begin
            v = {16'(id), 16'(i), 32'h5A5A_0000 ^ 32'(id * 131 + i),
                 64'(id * 1000 + i + 1) ^ 64'hF0F0_0000_0000_0000};
            el[i] = (i == n - 1 && uns) ? {64'h0, v[63:0]} : v;
            ln_dat.push_back(v);
            ln_sop.push_back(i == 0);
            ln_eop.push_back(i == n - 1);
            ln_err.push_back(err && i == 2);
            ln_junk.push_back(junk);
            ln_uns.push_back(i == n - 1 && uns);
        end
        for (int j = 0; j < n; j += 2) begin
            ex_dat.push_back({(j + 1 < n) ? el[j+1] : 128'h0, el[j]});
            ex_sop.push_back(j == 0);
            ex_eop.push_back(j + 2 >= n);
            ex_err.push_back(err && (j + 2 >= n));
            ex_tag.push_back((j + 2 >= n && uns) ? "R10" : tag);
        end
    endtask

    task automatic wait_drain(input int lim);
        int k = 0;
        while ((ln_dat.size() > 0 || ex_dat.size() > 0) && k < lim) begin
            @(posedge clk);
            k++;
        end
        checks++;
        if (ex_dat.size() != 0)
            fail("R12", "beats missing after drain", 256'(ex_dat.size()), 256'h0);
    endtask

    // per-cycle driver, model comparison and sink ready
    initial begin : cyc_proc
        bit r;
        logic [127:0] a, b;
        bit sa, sb, ea, eb, ra, rb, ja, jb, ua, ub;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                in_vld = 0; out_rdy = 0;
                {o0, o1, o2, h0, h1} = '0;
            end else begin
                cyc++;
                if (cyc > 150000) begin
                    errors++;
                    $display("FAIL watchdog expired");
                    summary_and_end();
                end
                if (out_vld) begin
                    checks++;
                    if (!o2) fail("R3", "valid without ready 3 cycles before", 256'(out_vld), 256'h0);
                    if (ex_dat.size() == 0) begin
                        checks++;
                        fail("R12", "unexpected beat", out_dat, 256'h0);
                    end else begin
                        checks += 3;
                        if (out_dat !== ex_dat[0])
                            fail(ex_tag[0], "beat data", out_dat, ex_dat[0]);
                        if ({out_sop, out_eop} !== {ex_sop[0], ex_eop[0]})
                            fail("R4", "sop/eop", 256'({out_sop, out_eop}), 256'({ex_sop[0], ex_eop[0]}));
                        if (out_err !== ex_err[0])
                            fail("R9", "err replay", 256'(out_err), 256'(ex_err[0]));
                        if (out_err && !out_eop)
                            fail("R11", "err without eop", 256'(out_eop), 256'h1);
                        void'(ex_dat.pop_front()); void'(ex_sop.pop_front());
                        void'(ex_eop.pop_front()); void'(ex_err.pop_front());
                        void'(ex_tag.pop_front());
                    end
                end
                case (omode)
                    1:       r = 1;
                    2:       r = 0;
                    default: r = ($urandom % 3) != 0;
                endcase
                out_rdy = r;
                o2 = o1; o1 = o0; o0 = r;
                in_vld = 0;
                if (h1 && ln_dat.size() > 0 && ($urandom % 5) != 0) begin
                    if (ln_dat.size() == 1) idle_lane();
                    a = ln_dat.pop_front(); b = ln_dat.pop_front();
                    sa = ln_sop.pop_front(); sb = ln_sop.pop_front();
                    ea = ln_eop.pop_front(); eb = ln_eop.pop_front();
                    ra = ln_err.pop_front(); rb = ln_err.pop_front();
                    ja = ln_junk.pop_front(); jb = ln_junk.pop_front();
                    ua = ln_uns.pop_front(); ub = ln_uns.pop_front();
                    in_dat   = {b, a};
                    in_sop   = {sb, sa};
                    in_eop   = {eb, ea};
                    in_err   = {ja | jb, ra | rb};
                    in_empty = {ja | jb, ua | ub};
                    in_vld   = 1;
                end
                h1 = h0; h0 = in_rdy;
            end
        end
    end

    initial begin : main
        rst_n = 0;
        repeat (4) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (in_rdy !== 1'b1) fail("R1", "in_rdy after reset", 256'(in_rdy), 256'h1);
        checks++;
        if ({out_vld, out_sop, out_eop, out_err} !== 4'b0)
            fail("R1", "outputs after reset", 256'({out_vld, out_sop, out_eop, out_err}), 256'h0);

        // R2: sink held off, source keeps offering
        omode = 2;
        for (int p = 0; p < 10; p++) add_pkt(p, 2 + p % 3, 0, 0, 0, 0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        checks++;
        if (in_rdy !== 1'b0) fail("R2", "in_rdy with full buffer", 256'(in_rdy), 256'h0);
        checks++;
        if (out_vld !== 1'b0) fail("R3", "valid while sink held off", 256'(out_vld), 256'h0);
        omode = 0;
        wait_drain(4000);

        // R5 R9 R10: shared beats with ready held high
        omode = 1;
        for (int p = 0; p < 12; p++)
            add_pkt(100 + p, (p % 4 == 3) ? 6 : 3, (p % 4 == 3), (p % 3 == 1), (p % 5 == 2), 0);
        for (int p = 0; p < 6; p++) add_pkt(120 + p, 1, 0, p % 2, 0, p % 2);
        wait_drain(4000);

        // R6 R7 R8 R9 R10: random mix, random sink ready
        omode = 0;
        for (int p = 0; p < 80; p++) begin
            int n;
            n = 1 + $urandom % 8;
            add_pkt(200 + p, n, (n >= 5) && ($urandom % 2 == 1), $urandom % 2,
                    ($urandom % 3) == 0, (($urandom % 4) == 0) ? 1 + $urandom % 2 : 0);
        end
        wait_drain(20000);

        // same shared-beat pattern with random ready
        for (int p = 0; p < 12; p++)
            add_pkt(400 + p, (p % 4 == 1) ? 5 : 3, (p % 4 == 1), p % 2, p % 2, 0);
        wait_drain(4000);
        repeat (10) @(posedge clk);
        summary_and_end();
    end
endmodule